// File: doc/BRIEF.md
# Masked Tile Sum-of-Absolute-Differences Accumulator

This unit compares two 4x4 tiles of unsigned 8-bit pixels and reports how far apart they are. For each of the sixteen positions it takes the absolute difference between the reference pixel and the candidate pixel, adds the sixteen values together, and adds that total to an accumulator value supplied with the tile. Motion search, block matching and similar image-processing loops use it to score candidate blocks. The caller feeds each score back as the next accumulator input, or starts a new score from zero.

Two controls travel with every tile. The first is the mask enable. When it is set, any position whose reference pixel is zero is treated as background and adds nothing to the total. The second selects the accumulator width. In wide mode the sum is 32 bits and wraps around. In narrow mode only the low 16 bits are used and the result clamps at the 16-bit maximum.

The unit accepts one tile on every clock and returns each result two cycles after it was accepted. Both tiles are packed row-major: pixel i occupies bits [8i+7:8i].

Top module: `tile_sad_acc`

## Requirements
- R1: While reset is asserted, and after it is released with no tile issued, `res_valid` is 0 and `acc_res` is 0.
- R2: `res_valid` is high exactly two rising edges after a rising edge at which `tile_valid` was high, and low otherwise.
- R3: With `mask_on` = 0, the tile total is the sum over i = 0..15 of |ref byte i − cand byte i|, where byte i is bits [8i+7:8i] of the tile bus. The total is at most 4080.
- R4: With `mask_on` = 1, every position whose reference byte is 0x00 contributes nothing to the total, whatever its candidate byte holds.
- R5: With `mask_on` = 0, positions whose reference byte is 0x00 contribute their full candidate value.
- R6: With `wide_mode` = 1, `acc_res` = (`acc_seed` + total) mod 2^32.
- R7: With `wide_mode` = 0, `acc_res[31:16]` is 0 and `acc_res[15:0]` = min(`acc_seed[15:0]` + total, 0xFFFF). Bits [31:16] of `acc_seed` are ignored.
- R8: Tiles issued on consecutive clocks each produce their own correct result, in issue order, on consecutive clocks.
- R9: `acc_res` changes only at an edge that raises or keeps `res_valid` high. While `res_valid` is low it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_valid | input | 1 | The tile and controls on the inputs are to be processed |
| ref_pix | input | 128 | Reference tile, pixel i in bits [8i+7:8i], row-major |
| cand_pix | input | 128 | Candidate tile, same packing |
| mask_on | input | 1 | 1: reference pixels equal to zero are excluded |
| wide_mode | input | 1 | 1: 32-bit wrapping accumulate; 0: 16-bit saturating |
| acc_seed | input | 32 | Accumulator value the tile total is added to |
| res_valid | output | 1 | `acc_res` carries a new result |
| acc_res | output | 32 | Updated accumulator |

## Verification
The assertions check several properties on every cycle. The output strobe must follow the input strobe by exactly two edges. The result must hold steady whenever no result is flagged. Narrow results must keep their upper half clear. A wide result may exceed its seed by no more than the largest possible tile total. A tile whose reference is entirely background, or whose two tiles are identical, must return its seed unchanged. Only the bench scenarios show the exact arithmetic. That covers how a single byte position maps to a mask decision, wrap-around of a 32-bit seed, the clamp edge in narrow mode, and a stream of back-to-back tiles each checked against its own expected total.

// File: rtl/tsad_pkg.sv
package tsad_pkg;
  localparam int PIX_W    = 8;
  localparam int TILE_DIM = 4;
  localparam int ACC_W    = 32;
  localparam int NARROW_W = 16;

  localparam int NPIX   = TILE_DIM * TILE_DIM;
  localparam int TILE_W = NPIX * PIX_W;
  localparam int ROW_W  = PIX_W + $clog2(TILE_DIM);
  localparam int SAD_W  = PIX_W + $clog2(NPIX);

  typedef struct packed {
    logic             wide;
    logic [ACC_W-1:0] seed;
  } acc_ctl_t;
endpackage

// File: rtl/tsad_absdiff.sv
module tsad_absdiff #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] ref_px,
  input  logic [PIX_W-1:0] cand_px,
  input  logic             mask_on,
  output logic [PIX_W-1:0] diff
);
  logic background;
  logic [PIX_W-1:0] raw;

  always_comb begin
    background = mask_on && (ref_px == '0);
    raw  = (ref_px >= cand_px) ? (ref_px - cand_px) : (cand_px - ref_px);
    diff = background ? '0 : raw;
  end
endmodule

// File: rtl/tsad_row_sum.sv
module tsad_row_sum #(
  parameter int PIX_W = 8,
  parameter int N     = 4,
  localparam int OUT_W = PIX_W + $clog2(N)
) (
  input  logic [N-1:0][PIX_W-1:0] terms,
  output logic [OUT_W-1:0]        total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < N; k++) begin
      total = total + OUT_W'(terms[k]);
    end
  end
endmodule

// File: rtl/tsad_accum.sv
module tsad_accum #(
  parameter int SAD_W    = 12,
  parameter int ACC_W    = 32,
  parameter int NARROW_W = 16,
  localparam int NSUM_W  = ((NARROW_W > SAD_W) ? NARROW_W : SAD_W) + 1
) (
  input  logic [SAD_W-1:0] sad,
  input  logic [ACC_W-1:0] seed,
  input  logic             wide,
  output logic [ACC_W-1:0] result
);
  logic [ACC_W-1:0]  wide_sum;
  logic [NSUM_W-1:0] narrow_sum;
  logic              narrow_ovf;
  logic [NARROW_W-1:0] narrow_res;

  always_comb begin
    wide_sum   = seed + ACC_W'(sad);
    narrow_sum = NSUM_W'(seed[NARROW_W-1:0]) + NSUM_W'(sad);
    narrow_ovf = (narrow_sum >> NARROW_W) != '0;
    narrow_res = narrow_ovf ? '1 : narrow_sum[NARROW_W-1:0];
    result     = wide ? wide_sum : ACC_W'(narrow_res);
  end
endmodule

// File: rtl/tile_sad_acc.sv
module tile_sad_acc
  import tsad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tile_valid,
  input  logic [TILE_W-1:0] ref_pix,
  input  logic [TILE_W-1:0] cand_pix,
  input  logic              mask_on,
  input  logic              wide_mode,
  input  logic [ACC_W-1:0]  acc_seed,
  output logic              res_valid,
  output logic [ACC_W-1:0]  acc_res
);
  // per-pixel differences
  logic [NPIX-1:0][PIX_W-1:0] diffs;

  for (genvar i = 0; i < NPIX; i++) begin : g_px
    tsad_absdiff #(.PIX_W(PIX_W)) u_ad (
      .ref_px  (ref_pix[i*PIX_W +: PIX_W]),
      .cand_px (cand_pix[i*PIX_W +: PIX_W]),
      .mask_on (mask_on),
      .diff    (diffs[i])
    );
  end

  // first tree level: one partial sum per row
  logic [TILE_DIM-1:0][ROW_W-1:0] row_tot;

  for (genvar r = 0; r < TILE_DIM; r++) begin : g_row
    tsad_row_sum #(.PIX_W(PIX_W), .N(TILE_DIM)) u_rs (
      .terms (diffs[r*TILE_DIM +: TILE_DIM]),
      .total (row_tot[r])
    );
  end

  // stage 1 registers
  logic                           s1_vld_q, s1_vld_d;
  logic [TILE_DIM-1:0][ROW_W-1:0] s1_rows_q, s1_rows_d;
  acc_ctl_t                       s1_ctl_q, s1_ctl_d;
  logic                           s1_en;

  always_comb begin
    s1_en     = tile_valid;
    s1_vld_d  = tile_valid;
    s1_rows_d = row_tot;
    s1_ctl_d  = '{wide: wide_mode, seed: acc_seed};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_rows_q <= '0;
      s1_ctl_q  <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_en) begin
        s1_rows_q <= s1_rows_d;
        s1_ctl_q  <= s1_ctl_d;
      end
    end
  end

  // second tree level and accumulate
  logic [TILE_DIM-1:0][SAD_W-1:0] rows_ext;
  logic [SAD_W-1:0]               tile_sad;
  logic [ACC_W-1:0]               acc_next;

  for (genvar r = 0; r < TILE_DIM; r++) begin : g_ext
    assign rows_ext[r] = SAD_W'(s1_rows_q[r]);
  end

  tsad_row_sum #(.PIX_W(SAD_W), .N(TILE_DIM)) u_final (
    .terms (rows_ext),
    .total ({tile_sad_hi, tile_sad})
  );

  logic [$clog2(TILE_DIM)-1:0] tile_sad_hi;

  tsad_accum #(.SAD_W(SAD_W), .ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_acc (
    .sad    (tile_sad),
    .seed   (s1_ctl_q.seed),
    .wide   (s1_ctl_q.wide),
    .result (acc_next)
  );

  // stage 2 registers
  logic             s2_vld_q, s2_vld_d;
  logic [ACC_W-1:0] s2_acc_q, s2_acc_d;
  logic             s2_en;

  always_comb begin
    s2_en    = s1_vld_q;
    s2_vld_d = s1_vld_q;
    s2_acc_d = acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_acc_q <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      if (s2_en) s2_acc_q <= s2_acc_d;
    end
  end

  assign res_valid = s2_vld_q;
  assign acc_res   = s2_acc_q;
endmodule

// File: rtl/tsad_checker.sv
module tsad_checker #(
  parameter int TILE_W   = 128,
  parameter int ACC_W    = 32,
  parameter int NARROW_W = 16,
  parameter int MAX_SAD  = 4080
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tile_valid,
  input logic [TILE_W-1:0] ref_pix,
  input logic [TILE_W-1:0] cand_pix,
  input logic              mask_on,
  input logic              wide_mode,
  input logic [ACC_W-1:0]  acc_seed,
  input logic              res_valid,
  input logic [ACC_W-1:0]  acc_res
);
  localparam logic [ACC_W-1:0] SAD_CAP = ACC_W'(MAX_SAD);

  p_lat_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid |-> ##2 res_valid);

  p_lat_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tile_valid |-> ##2 !res_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(acc_res));

  p_narrow_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(wide_mode, 2)) |-> (acc_res[ACC_W-1:NARROW_W] == '0));

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(wide_mode, 2)) |-> ((acc_res - $past(acc_seed, 2)) <= SAD_CAP));

  p_all_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(wide_mode && mask_on && (ref_pix == '0), 2))
      |-> (acc_res == $past(acc_seed, 2)));

  p_same_tile_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(wide_mode && (ref_pix == cand_pix), 2))
      |-> (acc_res == $past(acc_seed, 2)));
endmodule

bind tile_sad_acc tsad_checker #(
  .TILE_W   (tsad_pkg::TILE_W),
  .ACC_W    (tsad_pkg::ACC_W),
  .NARROW_W (tsad_pkg::NARROW_W),
  .MAX_SAD  (tsad_pkg::NPIX * ((1 << tsad_pkg::PIX_W) - 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tile_valid (tile_valid),
  .ref_pix    (ref_pix),
  .cand_pix   (cand_pix),
  .mask_on    (mask_on),
  .wide_mode  (wide_mode),
  .acc_seed   (acc_seed),
  .res_valid  (res_valid),
  .acc_res    (acc_res)
);

// File: tb/sim_tile_sad_acc.sv
`timescale 1ns/1ps
module sim_tile_sad_acc;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tile_valid;
  logic [127:0] ref_pix, cand_pix;
  logic         mask_on, wide_mode;
  logic [31:0]  acc_seed;
  logic         res_valid;
  logic [31:0]  acc_res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tile_sad_acc u0 (
    .clk(clk), .rst_n(rst_n), .tile_valid(tile_valid),
    .ref_pix(ref_pix), .cand_pix(cand_pix), .mask_on(mask_on),
    .wide_mode(wide_mode), .acc_seed(acc_seed),
    .res_valid(res_valid), .acc_res(acc_res)
  );

  function automatic logic [31:0] model(logic [127:0] r, logic [127:0] c,
                                        logic m, logic w, logic [31:0] s);
    int tot = 0;
    int nsum;
    for (int i = 0; i < 16; i++) begin
      int a = int'(r[8*i +: 8]);
      int b = int'(c[8*i +: 8]);
      if (!(m && a == 0)) tot += (a > b) ? a - b : b - a;
    end
    if (w) return s + 32'(tot);
    nsum = int'(s[15:0]) + tot;
    return (nsum > 65535) ? 32'h0000_FFFF : 32'(nsum);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [127:0] r, logic [127:0] c, logic m, logic w, logic [31:0] s);
    tile_valid = 1'b1; ref_pix = r; cand_pix = c;
    mask_on = m; wide_mode = w; acc_seed = s;
  endtask

  task automatic idle();
    tile_valid = 1'b0;
  endtask

  // issue one tile at a negedge, check latency and value
  task automatic one_tile(string req, logic [127:0] r, logic [127:0] c,
                          logic m, logic w, logic [31:0] s, logic [31:0] exp);
    put(r, c, m, w, s);
    @(negedge clk); idle();
    chk({req, "/R2 early"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    chk({req, "/R2 valid"}, 32'(res_valid), 32'd1);
    chk(req, acc_res, exp);
    @(negedge clk);
    chk({req, "/R2 drop"}, 32'(res_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(res_valid), 32'd0);
    chk("R1 acc", acc_res, 32'd0);
  endtask

  task automatic t_unmasked();
    logic [127:0] r, c;
    r = {16{8'hFF}}; c = '0;
    one_tile("R3 max", r, c, 1'b0, 1'b1, 32'd0, 32'd4080);
    for (int i = 0; i < 16; i++) begin
      r[8*i +: 8] = 8'(i * 16);
      c[8*i +: 8] = 8'(255 - i * 9);
    end
    one_tile("R3 ramp", r, c, 1'b0, 1'b1, 32'd100, model(r, c, 1'b0, 1'b1, 32'd100));
  endtask

  task automatic t_mask();
    logic [127:0] r, c;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'(i + 1);
    r[8*5 +: 8] = 8'h00;
    c = r;
    c[8*5 +: 8] = 8'd100;
    c[7:0] = 8'd8;
    one_tile("R4 pos5", r, c, 1'b1, 1'b1, 32'd0, 32'd7);
    one_tile("R5 unmasked", r, c, 1'b0, 1'b1, 32'd0, 32'd107);
    one_tile("R4 all bg", '0, {16{8'hC3}}, 1'b1, 1'b1, 32'd55, 32'd55);
  endtask

  task automatic t_wide();
    one_tile("R6 wrap", {16{8'hFF}}, '0, 1'b0, 1'b1, 32'hFFFF_FFF0, 32'h0000_0FE0);
    one_tile("R6 high", {16{8'h01}}, {16{8'h03}}, 1'b0, 1'b1, 32'h1234_0000, 32'h1234_0020);
  endtask

  task automatic t_narrow();
    one_tile("R7 clamp", {16{8'hFF}}, '0, 1'b0, 1'b0, 32'hABCD_FF00, 32'h0000_FFFF);
    one_tile("R7 edge", {16{8'hFF}}, '0, 1'b0, 1'b0, 32'h0000_F00F, 32'h0000_FFFF);
    one_tile("R7 below", {16{8'hFF}}, '0, 1'b0, 1'b0, 32'h0000_F00E, 32'h0000_FFFE);
    one_tile("R7 seed hi", {16{8'h05}}, '0, 1'b0, 1'b0, 32'h1234_0010, 32'h0000_0060);
  endtask

  task automatic t_stream();
    logic [127:0] rs [6];
    logic [127:0] cs [6];
    logic [31:0]  ex [6];
    for (int j = 0; j < 6; j++) begin
      for (int i = 0; i < 16; i++) begin
        rs[j][8*i +: 8] = 8'((i * 37 + j * 11) % 256);
        cs[j][8*i +: 8] = 8'((i * 53 + j * 29 + 7) % 256);
      end
      if (j == 3) rs[j][8*2 +: 8] = 8'h00;
      ex[j] = model(rs[j], cs[j], j[0], j != 4, 32'(j * 1000 + 65000));
    end
    for (int j = 0; j < 8; j++) begin
      if (j >= 2) begin
        chk("R8 valid", 32'(res_valid), 32'd1);
        chk("R8 value", acc_res, ex[j-2]);
      end
      if (j < 6) put(rs[j], cs[j], j[0], j != 4, 32'(j * 1000 + 65000));
      else idle();
      @(negedge clk);
    end
    chk("R8 end", 32'(res_valid), 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] last;
    one_tile("R9 prime", {16{8'h10}}, '0, 1'b0, 1'b1, 32'd1, 32'd257);
    last = acc_res;
    for (int k = 0; k < 4; k++) begin
      tile_valid = 1'b0;
      ref_pix = {16{8'(k + 40)}}; cand_pix = '0;
      acc_seed = 32'(k * 777); wide_mode = k[0];
      @(negedge clk);
      chk("R9 hold", acc_res, last);
      chk("R9 no valid", 32'(res_valid), 32'd0);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; tile_valid = 1'b0; ref_pix = '0; cand_pix = '0;
    mask_on = 1'b0; wide_mode = 1'b1; acc_seed = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_unmasked();
    t_mask();
    t_wide();
    t_narrow();
    t_stream();
    t_hold();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule